// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a set of gated output clocks, one per channel, each derived from one of two shared sources: a 32768 Hz low-speed clock and a high-speed clock of about 4 MHz. Both sources arrive as one-cycle edge strobes in the system clock domain. `slow_edge` pulses once for every edge of the low-speed source, rising or falling, and `fast_edge` does the same for the high-speed source. A channel output that toggles on every strobe therefore runs at the frequency of its source.

Each channel has one 8-bit control register. It holds an enable, a source select, a power-of-two divider exponent and a pre-divider code. The pre-divider acts only on the high-speed source. Its ratio table is 1, 2, 4, 8, 16, 32, 64 and then 122, not 128. The registers sit at consecutive addresses, one per channel.

A written setting is held as pending and becomes active only while the channel output is low. An enable, source or divider change therefore never cuts a high phase short and never produces a runt pulse.

Top module: `clkout_gen`

## Requirements
- R1: While reset is asserted, and right after it is released, every output is low and every channel is disabled with all fields zero.
- R2: The control byte has these fields: bit 0 enable, bits 3:1 divider exponent n, bit 4 source (0 = low-speed, 1 = high-speed), bits 7:5 pre-divider code. Channel k is written when `cfg_we` is high and `cfg_addr` equals k. A write to an address at or above the channel count changes no channel.
- R3: With the low-speed source active, the output toggles once every 2^n `slow_edge` strobes, and the pre-divider code has no effect.
- R4: With the high-speed source active, the output toggles once every P x 2^n `fast_edge` strobes. P is 2^code for codes 0 to 6 and 122 for code 7. With code 7 the output therefore stays high and low for 61 source periods each.
- R5: Strobes from the source that is not selected do not change the output.
- R6: A channel whose active enable is 0 holds its output low, whatever strobes arrive.
- R7: A pending setting that differs from the active one is applied only in a cycle where the output is low. If it is written while the output is high, the high phase finishes under the old setting and the new setting is applied after the falling edge.
- R8: Applying a setting restarts both divider stages. The first rising edge comes exactly after the full divide count of selected-source strobes.
- R9: The output changes only at the clock edge that samples a strobe. It holds its level through any stretch without strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | ADDR_W | Channel index of the write |
| cfg_wdata | input | 8 | Control byte to write |
| slow_edge | input | 1 | One-cycle strobe per edge of the 32768 Hz source |
| fast_edge | input | 1 | One-cycle strobe per edge of the high-speed source |
| clk_out | output | NUM_CH | Divided, gated output clock per channel |

## Verification
The divider is driven with strobe counts one short of a toggle, exactly at a toggle, and at twice the toggle count. These counts separate an off-by-one error from a wrong ratio. The largest ratio (pre-divide 64 with exponent 7) and the odd 122 ratio are both covered, and the 122 cases tell a true 122 apart from a 128 reading of the top code. Other patterns strobe the unselected source, set a pre-divider code while the low-speed source is selected, and write an out-of-range address. These show whether the source mux, the pre-divider bypass and the address decode leak into the output. Setting changes written mid-period separate an output that waits for its low phase and restarts its counters from one that changes immediately or keeps old counts.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CTRL_W = 8;
  localparam int EXP_W  = 3;
  localparam int PRE_W  = 3;

  // Field order is the register bit layout, MSB first.
  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             sel;
    logic [EXP_W-1:0] expo;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/clkout_prediv.sv
module clkout_prediv #(
  parameter int PRE_W     = 3,
  parameter int ODD_RATIO = 122
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bypass,
  input  logic             tick,
  input  logic [PRE_W-1:0] code,
  output logic             tick_out
);
  localparam int MAX_POW = 1 << ((1 << PRE_W) - 2);
  localparam int MAX_R   = (ODD_RATIO > MAX_POW) ? ODD_RATIO : MAX_POW;
  localparam int CNT_W   = $clog2(MAX_R);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;
  logic             at_last;

  always_comb begin
    if (code == {PRE_W{1'b1}}) last_val = CNT_W'(ODD_RATIO - 1);
    else                       last_val = CNT_W'((32'd1 << code) - 32'd1);
  end

  assign at_last  = (cnt_q == last_val);
  assign tick_out = tick & ~clr & (bypass | at_last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || bypass)  cnt_d = '0;
    else if (tick)      cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkout_pow2div.sv
module clkout_pow2div #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [EXP_W-1:0] expo,
  output logic             fire
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;
  logic             at_last;

  assign last_val = CNT_W'((32'd1 << expo) - 32'd1);
  assign at_last  = (cnt_q == last_val);
  assign fire     = tick & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
  import clkout_pkg::*;
#(
  parameter int ODD_RATIO = 122
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_data,
  input  logic  slow_edge,
  input  logic  fast_edge,
  output logic  clk_out,
  output ctrl_t act_cfg
);
  ctrl_t pend_q, pend_d, act_q, act_d;
  logic  out_q, out_d;
  logic  apply, restart, src_tick, pre_tick, fire;

  // Swap in the pending setting only while the output is low.
  assign apply    = ~out_q & (pend_q != act_q);
  assign restart  = apply | ~act_q.en;
  assign src_tick = act_q.sel ? fast_edge : slow_edge;

  clkout_prediv #(.PRE_W(PRE_W), .ODD_RATIO(ODD_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .bypass(~act_q.sel),
    .tick(src_tick), .code(act_q.pre), .tick_out(pre_tick)
  );

  clkout_pow2div #(.EXP_W(EXP_W)) u_pow (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(pre_tick),
    .expo(act_q.expo), .fire(fire)
  );

  always_comb begin
    pend_d = wr_en ? wr_data : pend_q;
    act_d  = apply ? pend_q  : act_q;
    out_d  = fire  ? ~out_q  : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      out_q  <= out_d;
    end
  end

  assign clk_out = out_q;
  assign act_cfg = act_q;
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ODD_RATIO = 122,
  parameter int ADDR_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              slow_edge,
  input  logic              fast_edge,
  output logic [NUM_CH-1:0] clk_out
);
  localparam int FLAT_W = NUM_CH * CTRL_W;

  logic              rst_meta_q, rst_sync_n;
  logic [FLAT_W-1:0] act_flat;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic  hit;
    ctrl_t act;
    assign hit = cfg_we & (cfg_addr == ADDR_W'(i));
    clkout_chan #(.ODD_RATIO(ODD_RATIO)) u_chan (
      .clk(clk), .rst_n(rst_sync_n), .wr_en(hit), .wr_data(ctrl_t'(cfg_wdata)),
      .slow_edge(slow_edge), .fast_edge(fast_edge),
      .clk_out(clk_out[i]), .act_cfg(act)
    );
    assign act_flat[i*CTRL_W +: CTRL_W] = act;
  end
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slow_edge,
  input logic                fast_edge,
  input logic [NUM_CH-1:0]   clk_out,
  input logic [NUM_CH*8-1:0] act_flat
);
  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (clk_out == '0)); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[i]) |-> $past(slow_edge | fast_edge)); // R9
    AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out[i]) |-> $past(slow_edge | fast_edge)); // R9
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_flat[i*8] && !clk_out[i]) |=> !clk_out[i]); // R6
    AST_SWAP_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_flat[i*8 +: 8]) |-> (!$past(clk_out[i]) && !clk_out[i])); // R7
  end
endmodule

bind clkout_gen clkout_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .slow_edge(slow_edge), .fast_edge(fast_edge),
  .clk_out(clk_out), .act_flat(act_flat)
);

// File: tb/sim_clkout_gen.sv
module sim_clkout_gen;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 2;
  localparam int NVEC   = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [7:0]        cfg_wdata = '0;
  logic              slow_edge = 1'b0;
  logic              fast_edge = 1'b0;
  logic [NUM_CH-1:0] clk_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clkout_gen #(.NUM_CH(NUM_CH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slow_edge(slow_edge), .fast_edge(fast_edge),
    .clk_out(clk_out)
  );

  // {channel[27:26], ctrl[25:18], fast[17], strobes[16:1], expected level[0]}
  // ctrl: bit0 en, 3:1 exponent, 4 source, 7:5 pre-divider code
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd0, 8'h01, 1'b0, 16'd1,    1'b1}, // R3 divide 1
    {2'd0, 8'h01, 1'b0, 16'd2,    1'b0}, // R3
    {2'd1, 8'h07, 1'b0, 16'd7,    1'b0}, // R3 divide 8, one short
    {2'd1, 8'h07, 1'b0, 16'd8,    1'b1}, // R3
    {2'd2, 8'hE1, 1'b0, 16'd1,    1'b1}, // R3 pre code ignored
    {2'd2, 8'hE3, 1'b0, 16'd3,    1'b1}, // R3
    {2'd2, 8'hE3, 1'b0, 16'd4,    1'b0}, // R3
    {2'd0, 8'hF1, 1'b1, 16'd121,  1'b0}, // R4 ratio 122
    {2'd0, 8'hF1, 1'b1, 16'd122,  1'b1}, // R4
    {2'd0, 8'hF1, 1'b1, 16'd244,  1'b0}, // R4
    {2'd1, 8'h75, 1'b1, 16'd31,   1'b0}, // R4 8 x 4
    {2'd1, 8'h75, 1'b1, 16'd32,   1'b1}, // R4
    {2'd0, 8'hDF, 1'b1, 16'd8191, 1'b0}, // R4 64 x 128
    {2'd0, 8'hDF, 1'b1, 16'd8192, 1'b1}, // R4
    {2'd2, 8'h11, 1'b0, 16'd5,    1'b0}, // R5 other source strobed
    {2'd1, 8'h10, 1'b1, 16'd3,    1'b0}, // R6 disabled
    {2'd1, 8'h11, 1'b1, 16'd3,    1'b1}  // R4 divide 1, three toggles
  };

  task automatic check(input string tag, input logic [NUM_CH-1:0] got,
                       input logic [NUM_CH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: clk_out=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    slow_edge = 1'b0;
    fast_edge = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    cfg_addr = a;
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input logic fast, input int n);
    if (fast) fast_edge = 1'b1; else slow_edge = 1'b1;
    repeat (n) @(negedge clk);
    fast_edge = 1'b0;
    slow_edge = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 during reset", clk_out, '0);
    do_reset();
    check("R1 after release", clk_out, '0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [NUM_CH-1:0] expv;
      do_reset();
      write_cfg(VEC[v][27:26], VEC[v][25:18]);
      strobe(VEC[v][17], int'(VEC[v][16:1]));
      expv = '0;
      expv[VEC[v][27:26]] = VEC[v][0];
      check($sformatf("vector %0d (R3/R4/R5/R6)", v), clk_out, expv);
    end

    // R1: reset while running drops outputs
    do_reset();
    write_cfg(2'd0, 8'h01);
    strobe(1'b0, 1);
    check("R1 setup high", clk_out, 3'b001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset", clk_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: out-of-range address leaves every channel idle
    do_reset();
    write_cfg(2'd3, 8'h01);
    strobe(1'b0, 1);
    check("R2 address 3 ignored", clk_out, '0);

    // R9: output holds without strobes
    do_reset();
    write_cfg(2'd1, 8'h01);
    strobe(1'b0, 1);
    repeat (50) @(negedge clk);
    check("R9 hold high without strobes", clk_out, 3'b010);

    // R7: change written while high waits for the falling edge
    write_cfg(2'd1, 8'h03);
    strobe(1'b0, 1);
    check("R7 old ratio ends high phase", clk_out, 3'b000);
    repeat (2) @(negedge clk);
    strobe(1'b0, 1);
    check("R7 new ratio one short", clk_out, 3'b000);
    strobe(1'b0, 1);
    check("R7 new ratio applied", clk_out, 3'b010);

    // R6/R7: disable while high finishes the high phase, then stays low
    do_reset();
    write_cfg(2'd2, 8'h01);
    strobe(1'b0, 1);
    write_cfg(2'd2, 8'h00);
    check("R7 disable waits for low", clk_out, 3'b100);
    strobe(1'b0, 1);
    check("R7 falls on strobe", clk_out, 3'b000);
    repeat (2) @(negedge clk);
    strobe(1'b0, 6);
    strobe(1'b1, 6);
    check("R6 stays low once disabled", clk_out, 3'b000);

    // R8: applying a setting restarts the count
    do_reset();
    write_cfg(2'd0, 8'h05);
    strobe(1'b0, 2);
    write_cfg(2'd0, 8'h25);
    strobe(1'b0, 2);
    check("R8 count restarted", clk_out, 3'b000);
    strobe(1'b0, 2);
    check("R8 full count after apply", clk_out, 3'b001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule